// File: doc/BRIEF.md
# Serial EEPROM Sequential Read Engine

This block is the slave-side read path of a serial-bus EEPROM. It works in SPI mode 0. While the active-low chip select is held low, it shifts in an 8-bit instruction and then a 16-bit byte address, both most significant bit first. If the instruction is the read opcode and no internal write cycle is busy, it fetches bytes from the on-chip array through a synchronous read port. It returns them on the serial output, most significant bit first, one byte after another, for as long as chip select stays low. The byte address advances after every byte and wraps from the top of the array back to zero, so one command can sweep the whole array any number of times.

The serial pins are oversampled by the system clock. They are assumed to be already synchronised to `clk`. Each half-period of the serial clock must last at least six `clk` cycles, which gives the array fetch time to finish before the next output bit is due. Only the low `ADDR_W` bits of the received address select a byte, so one engine serves a 4 KiB array (`ADDR_W`=12), an 8 KiB array (`ADDR_W`=13), or any size from 256 B to 64 KiB. The serial output is presented as a data bit plus an output enable, and the pad turns these into a tri-state driver.

Top module: `serom_read_engine`

## Requirements
- R1: With `cs_n` low, `mosi` is sampled on each rising `sck` edge. The first 8 bits form the instruction (MSB first), and the read instruction is the value 8'h03. The next 16 bits form the address, most significant bit first.
- R2: Only address bits [ADDR_W-1:0] select the first byte; the upper received address bits have no effect on the data returned.
- R3: After the falling `sck` edge that follows the 24th rising edge, `miso` carries bit 7 of the addressed byte. Each later falling edge moves to the next lower bit, down to bit 0.
- R4: While `cs_n` stays low, the byte at the next address follows directly, with its bit 7 driven on the falling edge right after bit 0 of the previous byte and with no extra clocks.
- R5: After address 2^ADDR_W-1, the next byte is read from address 0.
- R6: Raising `cs_n` ends the transfer at any bit position, including inside the header or inside a byte. The next low period of `cs_n` starts again with a fresh instruction.
- R7: An instruction other than 8'h03 causes no array read, and `miso_oe` stays low until `cs_n` rises.
- R8: `miso_oe` is low during the 24 header bits and is low within one `clk` cycle whenever `cs_n` is high.
- R9: If `wr_busy` is high at the 8th rising `sck` edge, a read instruction is refused and behaves as in R7.
- R10: While `rst_n` is low, `miso_oe` and `mem_rd` are low.
- R11: Each started byte costs exactly one single-cycle `mem_rd` pulse. One pulse is issued after the header, and another on the rising edge of the last bit of every completed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, synchronised |
| sck | input | 1 | Serial clock, synchronised |
| mosi | input | 1 | Serial data in |
| wr_busy | input | 1 | High while an internal write cycle is in progress |
| mem_rdata | input | 8 | Array read data, valid one cycle after `mem_rd` |
| mem_rd | output | 1 | Array read strobe |
| mem_addr | output | ADDR_W | Array read address |
| miso | output | 1 | Serial data out value |
| miso_oe | output | 1 | Output enable for the serial data out driver |

## Verification
The bench goes after the top-of-array wrap, addresses whose upper bits are set, aborts in the middle of the header and in the middle of a byte, unknown opcodes, and a read issued while `wr_busy` is high. A design without the wrap would read past the array or stall at its top address. A design that does not mask the address would return data from the wrong byte. If an aborted transfer left the bit counters mid-count, the next command would be decoded out of phase. A design that ignores busy or unknown opcodes would drive the bus and pulse `mem_rd`. A late prefetch would show up as a wrong or stale first bit in the second byte.

// File: rtl/serom_pkg.sv
package serom_pkg;
  localparam int CMD_BITS = 8;
  localparam int ADR_BITS = 16;
  localparam logic [CMD_BITS-1:0] OP_READ = 8'h03;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_DEAD = 2'd3
  } phase_t;

  // Instruction is honoured only when it is a read and the array is idle.
  function automatic logic op_accept(input logic [CMD_BITS-1:0] op,
                                     input logic busy);
    return (op == OP_READ) && !busy;
  endfunction
endpackage

// File: rtl/serom_edge.sv
module serom_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  output logic sck_rise,
  output logic sck_fall
);
  logic sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  assign sck_rise = ~cs_n &  sck & ~sck_q;
  assign sck_fall = ~cs_n & ~sck &  sck_q;
endmodule

// File: rtl/serom_hdr.sv
module serom_hdr
  import serom_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck_rise,
  input  logic              mosi,
  input  logic              wr_busy,
  output phase_t            phase,
  output logic              hdr_done,
  output logic [ADDR_W-1:0] start_addr
);
  localparam int CNT_W = $clog2(ADR_BITS);

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] sh;

  // Keeps only the low ADDR_W received bits; older bits fall off the top.
  function automatic logic [ADDR_W-1:0] shift_in(input logic [ADDR_W-1:0] s,
                                                 input logic b);
    return {s[ADDR_W-2:0], b};
  endfunction

  wire last_cmd_bit = (phase == PH_CMD)  && (cnt == CNT_W'(CMD_BITS-1));
  wire last_adr_bit = (phase == PH_ADDR) && (cnt == CNT_W'(ADR_BITS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      cnt      <= '0;
      sh       <= '0;
      hdr_done <= 1'b0;
    end else begin
      hdr_done <= 1'b0;
      if (cs_n) begin
        phase <= PH_CMD;
        cnt   <= '0;
      end else if (sck_rise && (phase == PH_CMD || phase == PH_ADDR)) begin
        sh  <= shift_in(sh, mosi);
        cnt <= cnt + 1'b1;
        if (last_cmd_bit) begin
          cnt   <= '0;
          phase <= op_accept({sh[CMD_BITS-2:0], mosi}, wr_busy) ? PH_ADDR : PH_DEAD;
        end
        if (last_adr_bit) begin
          phase    <= PH_DATA;
          hdr_done <= 1'b1;
        end
      end
    end
  end

  assign start_addr = sh;

  AST_HDR_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |-> $past(phase) == PH_ADDR); // R1
  AST_FRESH_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (phase == PH_CMD)); // R6
  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sck_rise && last_cmd_bit && wr_busy) |=> (phase == PH_DEAD)); // R9
endmodule

// File: rtl/serom_stream.sv
module serom_stream #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              hdr_done,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [7:0]        mem_rdata,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              miso,
  output logic              data_oe
);
  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

  logic              active, rd_q, rd_pend, oe_q;
  logic [2:0]        dbit;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        hold, obyte;

  // Next byte address; the ADDR_W-bit sum wraps the top of the array to zero.
  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  wire byte_end = active & sck_rise & (dbit == 3'd7);
  wire load_now = active & sck_fall & (dbit == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      rd_q    <= 1'b0;
      rd_pend <= 1'b0;
      oe_q    <= 1'b0;
      dbit    <= '0;
      addr_q  <= '0;
      hold    <= '0;
      obyte   <= '0;
    end else begin
      rd_q    <= 1'b0;
      rd_pend <= rd_q;
      if (rd_pend) hold <= mem_rdata;
      if (cs_n) begin
        active <= 1'b0;
        oe_q   <= 1'b0;
        dbit   <= '0;
      end else begin
        if (hdr_done) begin
          active <= 1'b1;
          addr_q <= start_addr;
          rd_q   <= 1'b1;
        end
        if (byte_end) begin
          addr_q <= step_addr(addr_q);
          rd_q   <= 1'b1;
        end
        if (active && sck_rise) dbit <= dbit + 1'b1;
        if (active && sck_fall) begin
          oe_q  <= 1'b1;
          obyte <= load_now ? hold : {obyte[6:0], 1'b0};
        end
      end
    end
  end

  assign mem_rd   = rd_q;
  assign mem_addr = addr_q;
  assign miso     = obyte[7];
  assign data_oe  = oe_q;

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && addr_q == ADDR_TOP) |=> (addr_q == '0)); // R5
  AST_OE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !oe_q); // R8
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |=> !rd_q); // R11
  AST_FETCH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |-> (!rd_q && !rd_pend)); // R4
endmodule

// File: rtl/serom_read_engine.sv
module serom_read_engine
  import serom_pkg::*;
#(
  parameter int ADDR_W = 12  // array size 2**ADDR_W bytes, 8..16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic              wr_busy,
  input  logic [7:0]        mem_rdata,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              miso,
  output logic              miso_oe
);
  logic              sck_rise, sck_fall, hdr_done, data_oe;
  logic [ADDR_W-1:0] start_addr;
  phase_t            phase;

  serom_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  serom_hdr #(.ADDR_W(ADDR_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise),
    .mosi(mosi), .wr_busy(wr_busy), .phase(phase),
    .hdr_done(hdr_done), .start_addr(start_addr)
  );

  serom_stream #(.ADDR_W(ADDR_W)) u_stream (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .hdr_done(hdr_done), .start_addr(start_addr),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .miso(miso), .data_oe(data_oe)
  );

  assign miso_oe = data_oe & ~cs_n;

  AST_REFUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DEAD) |-> (!mem_rd && !miso_oe)); // R7
  AST_OE_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (phase == PH_DATA)); // R8
endmodule

// File: tb/serom_read_engine_test.sv
module serom_read_engine_test;
  localparam int AW    = 12;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wr_busy = 1'b0;
  logic [7:0]    mem_rdata = 8'h00;
  logic          mem_rd, miso, miso_oe;
  logic [AW-1:0] mem_addr;
  int checks = 0, errors = 0, rd_count = 0;

  always #10 clk = ~clk;

  serom_read_engine #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wr_busy(wr_busy), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .miso(miso), .miso_oe(miso_oe)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37) ^ (a >> 5) ^ 8'h5C);
  endfunction

  function automatic int wrap_addr(input int a16, input int k);
    return (a16 + k) % DEPTH;
  endfunction

  always @(posedge clk) if (mem_rd) begin
    mem_rdata <= pat(int'(mem_addr));
    rd_count  <= rd_count + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic din, output logic dout, output logic doe);
    mosi = din;
    repeat (HALF) @(negedge clk);
    dout = miso; doe = miso_oe;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic end_txn(input string req);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1; wr_busy = 1'b0;
    @(negedge clk);
    chk(miso_oe == 1'b0, req, miso_oe, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic read_txn(input logic [7:0] op, input logic [15:0] a, input int nbits,
                          input bit busy, input string req);
    logic d, e;
    bit hdr_oe = 0, accept, oe_all = 1, oe_any = 0;
    int got = 0, k = 0, start_rd;
    accept = (op == 8'h03) && !busy;
    start_rd = rd_count;
    cs_n = 1'b0; wr_busy = busy;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 24; i++) begin
      xfer(i < 8 ? op[7-i] : a[23-i], d, e);
      if (e) hdr_oe = 1;
    end
    chk(!hdr_oe, "R8 header hi-z", hdr_oe, 0);
    for (int i = 0; i < nbits; i++) begin
      xfer(1'($urandom), d, e);
      got = (got << 1) | int'(d); k++;
      oe_all &= e; oe_any |= e;
      if (accept && (k == 8 || i == nbits - 1)) begin
        int exp = int'(pat(wrap_addr(int'(a), i / 8))) >> (8 - k);
        chk(oe_all && got == exp, req, got, exp);
        got = 0; k = 0; oe_all = 1;
      end
    end
    if (!accept) begin
      chk(!oe_any, {req, " R7/R9 no drive"}, oe_any, 0);
      chk(rd_count == start_rd, {req, " no array read"}, rd_count - start_rd, 0);
    end
    end_txn("R6 released");
    if (accept)
      chk(rd_count - start_rd == 1 + nbits / 8, "R11 read pulses",
          rd_count - start_rd, 1 + nbits / 8);
  endtask

  task automatic hdr_abort(input int nb);
    logic d, e;
    bit any = 0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      xfer(i < 8 ? 1'(8'h03 >> (7 - i)) : 1'b1, d, e);
      if (e) any = 1;
    end
    chk(!any, "R6 abort in header", any, 0);
    end_txn("R6 abort release");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    chk(miso_oe == 1'b0 && mem_rd == 1'b0, "R10 reset", {miso_oe, mem_rd}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_txn(8'h03, 16'h0000, 32, 0, "R1 R3 R4 stream");
    read_txn(8'h03, 16'hF123, 24, 0, "R2 upper bits ignored");
    read_txn(8'h03, 16'h0FFE, 40, 0, "R5 wrap to zero");
    read_txn(8'h03, 16'h0100, 13, 0, "R6 abort mid-byte");
    hdr_abort(11);
    read_txn(8'h03, 16'h0A55, 16, 0, "R6 fresh after abort");
    read_txn(8'h0B, 16'h0010, 16, 0, "R7 other opcode");
    read_txn(8'h03, 16'h0020, 16, 1, "R9 busy refuse");
    read_txn(8'h03, 16'h0FFF, 0, 0, "R11 header only");
    for (int n = 0; n < 24; n++) begin
      logic [7:0] op;
      op = ($urandom % 5 == 0) ? 8'($urandom) : 8'h03;
      read_txn(op, 16'($urandom), int'($urandom % 48), ($urandom % 6 == 0), "R4 random read");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule